// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block turns a 32-bit fixed-point word into an IEEE-754 single-precision value. Each operand comes with three controls: a signedness select, a half-width select that takes only the low 16 bits, and a count of fraction bits that says where the binary point sits. The converter builds an integer operand from these controls and takes its magnitude. It finds the leading one, shifts the significand into place and rounds it to 24 bits with round-to-nearest, ties to even. The fraction count is applied by subtracting it from the exponent.

The unit has two register stages. The first stage holds the extended operand's sign and magnitude. The second stage holds the packed float and an inexact flag. A new operand can enter on every cycle. Rounding always uses nearest-even, whatever rounding mode the surrounding datapath has for other conversions. With a 32-bit operand and at most 63 fraction bits, every nonzero result lands in the normal exponent range, so the unit never produces a denormal, an infinity or a NaN.

Top module: `fx2f_conv`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted operand, `out_valid` is 0 and `out_result` and `out_inexact` are 0.
- R2: An operand accepted with `in_valid` high at a rising edge produces `out_valid` high exactly two rising edges later; a cycle without `in_valid` produces `out_valid` low two edges later.
- R3: With `in_signed`=0 and `in_half`=0, all 32 bits are an unsigned integer, and the result is that integer divided by 2^`in_frac`, correctly rounded to single precision.
- R4: With `in_signed`=0 and `in_half`=1, only bits 15:0 are used and bits 31:16 have no effect on the result.
- R5: With `in_signed`=1 and `in_half`=1, bit 15 is sign-extended over the upper bits, and bits 31:16 of the input have no effect.
- R6: With `in_signed`=1, a negative operand gives a result with sign bit 31 set and the magnitude of the operand. 0x80000000 converts exactly to -2^31/2^`in_frac` (mantissa field 0).
- R7: An operand equal to zero in any mode gives 0x00000000 (+0.0) with `out_inexact`=0.
- R8: For a nonzero operand whose highest set magnitude bit is at position p, the exponent field in bits 30:23 equals 127 + p - `in_frac` (plus one on a rounding carry). `in_frac` ranges from 0 to 63.
- R9: When the discarded bits are exactly half an LSB, the significand rounds to the even value. It rounds up when they exceed half an LSB and down when they are below half.
- R10: A rounding increment that overflows the 24-bit significand gives mantissa field 0 and raises the exponent by one.
- R11: `out_inexact` is 1 exactly when nonzero magnitude bits were dropped by rounding; this can only happen when p is 24 or more.
- R12: While `out_valid` is 0, `out_result` and `out_inexact` hold the values of the last valid conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Fixed-point word |
| in_signed | input | 1 | 1: two's-complement operand, 0: unsigned |
| in_half | input | 1 | 1: use only bits 15:0 |
| in_frac | input | 6 | Number of fraction bits (divide by 2^in_frac) |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Single-precision result: sign 31, exponent 30:23, mantissa 22:0 |
| out_inexact | output | 1 | Nonzero bits were dropped by rounding |

## Verification
Two steps of the datapath can land on the same operand in one cycle: the rounding increment that carries out of the significand, and the exponent reduction by the fraction count. The carry must raise the exponent after `in_frac` has been subtracted. Operands of all ones at several fraction counts provoke this case, for example 0xFFFFFFFF with 32 fraction bits, which must give exactly 1.0 with the inexact flag set. A bench model checks each result. The model rounds by comparing the dropped remainder against half an LSB, so it does not reuse the guard/sticky structure of the RTL. The model is driven by seeded random operands in all four modes, with idle gaps placed between them.

// File: rtl/fx2f_pkg.sv
package fx2f_pkg;
  localparam int EXP_W  = 8;
  localparam int MANT_W = 23;
  localparam int BIAS   = 127;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
  } sp_word_t;
endpackage

// File: rtl/fx2f_operand.sv
module fx2f_operand #(
  parameter int IN_W   = 32,
  parameter int HALF_W = 16
) (
  input  logic [IN_W-1:0] din,
  input  logic            is_signed,
  input  logic            is_half,
  output logic            neg,
  output logic [IN_W-1:0] mag
);
  localparam int UP_W = IN_W - HALF_W;

  logic [IN_W-1:0] ext;
  logic            top_bit;

  always_comb begin
    top_bit = is_signed & din[HALF_W-1];
    if (is_half) begin
      ext = {{UP_W{top_bit}}, din[HALF_W-1:0]};
    end else begin
      ext = din;
    end
    neg = is_signed & ext[IN_W-1];
    // Two's-complement negate; the most negative value maps onto itself,
    // which read as unsigned is exactly its magnitude.
    mag = neg ? (~ext + {{(IN_W-1){1'b0}}, 1'b1}) : ext;
  end
endmodule

// File: rtl/fx2f_lead_one.sv
module fx2f_lead_one #(
  parameter int IN_W  = 32,
  parameter int POS_W = 5
) (
  input  logic [IN_W-1:0]  vec,
  output logic [POS_W-1:0] pos,
  output logic             any
);
  logic [IN_W-1:0] above;
  logic [IN_W-1:0] hit;

  assign above[IN_W-1] = 1'b0;
  genvar gi;
  generate
    for (gi = IN_W - 2; gi >= 0; gi--) begin : g_above
      assign above[gi] = above[gi+1] | vec[gi+1];
    end
    for (gi = 0; gi < IN_W; gi++) begin : g_hit
      assign hit[gi] = vec[gi] & ~above[gi];
    end
  endgenerate

  always_comb begin
    pos = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (hit[i]) pos = pos | POS_W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/fx2f_round.sv
module fx2f_round
  import fx2f_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int POS_W  = 5,
  parameter int FRAC_W = 6
) (
  input  logic [IN_W-1:0]   mag,
  input  logic [POS_W-1:0]  pos,
  input  logic              any,
  input  logic              neg,
  input  logic [FRAC_W-1:0] frac,
  output sp_word_t          result,
  output logic              inexact
);
  localparam int KEEP = MANT_W + 1;
  localparam int DROP = IN_W - KEEP;

  logic [IN_W-1:0]  norm;
  logic [POS_W-1:0] shamt;
  logic [KEEP-1:0]  sig;
  logic             guard;
  logic             sticky;
  logic             bump;
  logic [KEEP:0]    sum;
  logic             carry;
  int               exp_i;

  always_comb begin
    shamt  = POS_W'(IN_W - 1) - pos;
    norm   = mag << shamt;
    sig    = norm[IN_W-1 -: KEEP];
    guard  = norm[DROP-1];
    sticky = |norm[DROP-2:0];
    bump   = guard & (sticky | sig[0]);
    sum    = {1'b0, sig} + {{KEEP{1'b0}}, bump};
    carry  = sum[KEEP];
    exp_i  = BIAS + int'(pos) - int'(frac) + int'(carry);

    if (any) begin
      result.sign = neg;
      result.expo = EXP_W'(exp_i);
      result.mant = carry ? '0 : sum[MANT_W-1:0];
      inexact     = guard | sticky;
    end else begin
      result  = '0;
      inexact = 1'b0;
    end
  end
endmodule

// File: rtl/fx2f_conv.sv
module fx2f_conv
  import fx2f_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int HALF_W = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  input  logic              in_signed,
  input  logic              in_half,
  input  logic [FRAC_W-1:0] in_frac,
  output logic              out_valid,
  output logic [31:0]       out_result,
  output logic              out_inexact
);
  localparam int POS_W = $clog2(IN_W);

  // reset synchroniser: assert asynchronously, release on clock
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  // stage 1: operand extension
  logic            op_neg;
  logic [IN_W-1:0] op_mag;

  fx2f_operand #(.IN_W(IN_W), .HALF_W(HALF_W)) u_operand (
    .din       (in_data),
    .is_signed (in_signed),
    .is_half   (in_half),
    .neg       (op_neg),
    .mag       (op_mag)
  );

  logic              s1_valid_q, s1_valid_d;
  logic              s1_neg_q,   s1_neg_d;
  logic [IN_W-1:0]   s1_mag_q,   s1_mag_d;
  logic [FRAC_W-1:0] s1_frac_q,  s1_frac_d;

  always_comb begin
    s1_valid_d = in_valid;
    s1_neg_d   = s1_neg_q;
    s1_mag_d   = s1_mag_q;
    s1_frac_d  = s1_frac_q;
    if (in_valid) begin
      s1_neg_d  = op_neg;
      s1_mag_d  = op_mag;
      s1_frac_d = in_frac;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s1_valid_q <= 1'b0;
      s1_neg_q   <= 1'b0;
      s1_mag_q   <= '0;
      s1_frac_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_neg_q   <= s1_neg_d;
      s1_mag_q   <= s1_mag_d;
      s1_frac_q  <= s1_frac_d;
    end
  end

  // stage 2: normalise, round, pack
  logic [POS_W-1:0] lead_pos;
  logic             lead_any;
  sp_word_t         rnd_word;
  logic             rnd_inexact;

  fx2f_lead_one #(.IN_W(IN_W), .POS_W(POS_W)) u_lead (
    .vec (s1_mag_q),
    .pos (lead_pos),
    .any (lead_any)
  );

  fx2f_round #(.IN_W(IN_W), .POS_W(POS_W), .FRAC_W(FRAC_W)) u_round (
    .mag     (s1_mag_q),
    .pos     (lead_pos),
    .any     (lead_any),
    .neg     (s1_neg_q),
    .frac    (s1_frac_q),
    .result  (rnd_word),
    .inexact (rnd_inexact)
  );

  logic        o_valid_q, o_valid_d;
  sp_word_t    o_word_q,  o_word_d;
  logic        o_inex_q,  o_inex_d;

  always_comb begin
    o_valid_d = s1_valid_q;
    o_word_d  = o_word_q;
    o_inex_d  = o_inex_q;
    if (s1_valid_q) begin
      o_word_d = rnd_word;
      o_inex_d = rnd_inexact;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      o_valid_q <= 1'b0;
      o_word_q  <= '0;
      o_inex_q  <= 1'b0;
    end else begin
      o_valid_q <= o_valid_d;
      o_word_q  <= o_word_d;
      o_inex_q  <= o_inex_d;
    end
  end

  assign out_valid   = o_valid_q;
  assign out_result  = o_word_q;
  assign out_inexact = o_inex_q;
endmodule

// File: rtl/fx2f_conv_chk.sv
module fx2f_conv_chk #(
  parameter int FRAC_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_signed,
  input logic              in_half,
  input logic [FRAC_W-1:0] in_frac,
  input logic              out_valid,
  input logic [31:0]       out_result,
  input logic              out_inexact
);
  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R2
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R7
  zero_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[30:0] == 31'd0) |-> (!out_result[31] && !out_inexact));

  // R6
  sign_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[31]) |-> $past(in_signed, 2));

  // R4
  half_unsigned_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_half && !in_signed, 2)) |->
      (!out_result[31] && !out_inexact &&
       int'(out_result[30:23]) <= 142 - int'($past(in_frac, 2))));

  // R11
  inexact_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inexact) |->
      (int'(out_result[30:23]) >= 151 - int'($past(in_frac, 2))));

  // R12
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_result) && $stable(out_inexact)));
endmodule

bind fx2f_conv fx2f_conv_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_signed   (in_signed),
  .in_half     (in_half),
  .in_frac     (in_frac),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_inexact (out_inexact)
);

// File: tb/fx2f_conv_test.sv
module fx2f_conv_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_signed;
  logic        in_half;
  logic [5:0]  in_frac;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_inexact;

  int checks;
  int fails;

  fx2f_conv uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_signed(in_signed), .in_half(in_half), .in_frac(in_frac),
    .out_valid(out_valid), .out_result(out_result), .out_inexact(out_inexact)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // model: {inexact, sign, exponent, mantissa}
  function automatic logic [32:0] model(logic [31:0] d, bit s, bit h, int f);
    longint v, m, kept, rem, hf;
    bit neg, inex;
    int pos, sh, e;
    if (h) v = s ? longint'($signed(d[15:0])) : longint'({16'd0, d[15:0]});
    else   v = s ? longint'($signed(d))       : longint'({32'd0, d});
    neg = (v < 0);
    m = neg ? -v : v;
    if (m == 0) return 33'd0;
    pos = 0;
    for (int i = 0; i < 40; i++) if (((m >> i) & 1) != 0) pos = i;
    inex = 1'b0;
    if (pos <= 23) begin
      kept = m << (23 - pos);
    end else begin
      sh = pos - 23;
      kept = m >> sh;
      rem = m & ((longint'(1) << sh) - 1);
      hf = longint'(1) << (sh - 1);
      inex = (rem != 0);
      if (rem > hf || (rem == hf && kept[0])) kept = kept + 1;
      if (kept == (longint'(1) << 24)) begin
        kept = kept >> 1;
        pos++;
      end
    end
    e = 127 + pos - f;
    return {inex, neg, e[7:0], kept[22:0]};
  endfunction

  // bench-side pipeline of expectations
  bit          vh1, vh2;
  logic [32:0] eq1, eq2;
  string       tg1, tg2;
  logic [32:0] last;

  task automatic step(bit v, logic [31:0] d, bit s, bit h, int f, string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== vh2) begin
      fails++;
      $display("FAIL R2: out_valid got %b exp %b", out_valid, vh2);
    end
    if (vh2) begin
      checks++;
      if ({out_inexact, out_result} !== eq2) begin
        fails++;
        $display("FAIL %s: {inexact,result} got %b_%h exp %b_%h",
                 tg2, out_inexact, out_result, eq2[32], eq2[31:0]);
      end
      last = eq2;
    end else begin
      checks++; // R12: held while idle
      if ({out_inexact, out_result} !== last) begin
        fails++;
        $display("FAIL R12: held value got %b_%h exp %b_%h",
                 out_inexact, out_result, last[32], last[31:0]);
      end
    end
    vh2 = vh1; eq2 = eq1; tg2 = tg1;
    vh1 = v;
    eq1 = model(d, s, h, f);
    tg1 = tag;
    in_valid  = v;
    in_data   = d;
    in_signed = s;
    in_half   = h;
    in_frac   = 6'(f);
  endtask

  initial begin
    logic [31:0] rd;
    bit rs, rh;
    int rf;
    checks = 0; fails = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    in_signed = 1'b0; in_half = 1'b0; in_frac = '0;
    vh1 = 0; vh2 = 0; eq1 = '0; eq2 = '0; tg1 = ""; tg2 = ""; last = '0;
    void'($urandom(32'd20250601));
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'd0 || out_inexact !== 1'b0) begin
      fails++;
      $display("FAIL R1: got %b/%h/%b exp 0/00000000/0", out_valid, out_result, out_inexact);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'd0 || out_inexact !== 1'b0) begin
      fails++;
      $display("FAIL R1: after release got %b/%h/%b exp 0/00000000/0",
               out_valid, out_result, out_inexact);
    end

    // directed corner cases
    step(1, 32'h0000_0000, 0, 0, 0,  "R7");
    step(1, 32'h0000_0000, 1, 0, 5,  "R7");
    step(1, 32'hFFFF_0000, 1, 1, 3,  "R7");
    step(1, 32'h0000_0001, 0, 0, 0,  "R8");   // 1.0 = 3F800000
    step(1, 32'h0000_0001, 0, 0, 63, "R8");   // exponent 64
    step(1, 32'h8000_0000, 1, 0, 0,  "R6");   // CF000000
    step(0, 32'h0, 0, 0, 0, "idle");
    step(1, 32'h8000_0000, 1, 0, 31, "R6");   // -1.0 = BF800000
    step(1, 32'hFFFF_FFFF, 1, 0, 0,  "R6");   // -1.0
    step(1, 32'hFFFF_FFFF, 0, 0, 32, "R10");  // 1.0 inexact
    step(1, 32'hFFFF_FFFF, 0, 0, 0,  "R10");  // 4F800000 inexact
    step(1, 32'h01FF_FFFF, 0, 0, 4,  "R10");
    step(1, 32'h0100_0001, 0, 0, 0,  "R9");   // tie, even: down
    step(1, 32'h0100_0003, 0, 0, 0,  "R9");   // tie, odd: up
    step(1, 32'h0200_0003, 0, 0, 0,  "R9");   // above half: up
    step(1, 32'h0200_0001, 0, 0, 0,  "R9");   // below half: down
    step(1, 32'h00FF_FFFF, 0, 0, 0,  "R11");  // 24 bits, exact
    step(1, 32'h0100_0002, 0, 0, 0,  "R11");  // exact above 24 bits
    step(1, 32'hABCD_0001, 0, 1, 0,  "R4");   // upper ignored
    step(1, 32'h0000_0001, 0, 1, 0,  "R4");
    step(1, 32'h1234_FFFF, 1, 1, 0,  "R5");   // -1.0
    step(1, 32'h0000_8000, 1, 1, 63, "R5");
    step(1, 32'hFFFF_7FFF, 1, 1, 15, "R5");
    step(1, 32'h1234_5678, 0, 0, 12, "R3");
    step(0, 32'h0, 0, 0, 0, "idle");
    step(0, 32'h0, 0, 0, 0, "idle");

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      rd = $urandom();
      rd = rd >> ($urandom() % 32);
      rs = 1'($urandom());
      rh = 1'($urandom());
      rf = int'($urandom() % 64);
      if (($urandom() % 8) == 0) begin
        step(0, rd, rs, rh, rf, "idle");
      end else if (rs && !rh) begin
        if (($urandom() % 2) == 1) rd = ~rd;
        step(1, rd, rs, rh, rf, "R6");
      end else if (rs && rh) step(1, rd, rs, rh, rf, "R5");
      else if (rh)            step(1, rd, rs, rh, rf, "R4");
      else                    step(1, rd, rs, rh, rf, "R3");
    end
    for (int k = 0; k < 4; k++) step(0, 32'h0, 0, 0, 0, "idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule